// File: doc/BRIEF.md
# Legacy Interrupt Event Queue for a PCIe Root Port

This block sits in a PCIe root port and records legacy wire-interrupt events coming from devices below the port. Each event names the interrupt lane (A to D by default), whether the line is being raised or dropped, and the requester identifier of the device that sent it. Events go into a small circular queue. Software inspects the oldest entry through two head-word registers and retires it by writing to either of them.

A word-addressed register port gives access to the block. The registers are a pending-interrupt word with a matching mask, a link status word, a control/status word and the two head words. The block drives one level-sensitive interrupt line. It also drives a bridge-enable bit that the surrounding port uses to open its memory window.

Register map, by `reg_addr`: 0 pending word, 1 mask, 2 link status, 3 control/status, 4 head word A, 5 head word B. Addresses 6 and 7 are unmapped.

Top module: `rp_intx_queue`

## Requirements
- R1: After reset the queue is empty, `irq` and `bridge_en` are 0, and the pending word and mask read 0. The control/status word reads 0x2.
- R2: While the queue holds entries, head word A shows the oldest entry: bit 31 = 1, bit 16 = level (1 = raise), bits [LANE_W-1:0] = lane, all other bits 0. Head word B holds the requester identifier in bits [SRC_W-1:0]. Reading either head word does not remove the entry.
- R3: Reading either head word while the queue is empty returns 0.
- R4: A write to either head word removes exactly one entry, whatever the write data. A write while the queue is empty changes nothing.
- R5: Entries leave in arrival order. The queue holds DEPTH-1 entries. An event that arrives while the queue is full is dropped and sets the sticky overflow bit, control/status bit 2, which only reset clears.
- R6: Control/status bit 1 reads 1 when the queue is empty at the time of the read and 0 when entries are pending.
- R7: A control/status write loads only bit 0 into the bridge-enable bit, and `bridge_en` follows it on the next cycle. The other bits of the write data leave the other fields unchanged, except as R8 states.
- R8: Control/status bit 3 is set whenever an event is accepted into the queue. A control/status write with bit 3 = 1 clears it. An acceptance in the same cycle wins over the clear.
- R9: An accepted raise event sets pending bit [lane]. A dropped event sets pending bit [LANES]. Writing the pending word clears each bit written as 1; a set in the same cycle wins. Reading the pending word returns it.
- R10: The mask register stores all 32 written bits and reads them back. `irq` is 1 exactly when (pending AND mask) is nonzero, and it reflects a mask or pending change in the cycle after the write or event.
- R11: The link status word reads the `link_up` input in bit 0, with all other bits 0.
- R12: `reg_rdata` is loaded at the clock edge that samples `reg_rd` and holds until the next read. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | An interrupt event is presented this cycle |
| evt_lane | input | LANE_W | Interrupt lane of the event |
| evt_level | input | 1 | 1 = line raised, 0 = line dropped |
| evt_src | input | SRC_W | Requester identifier of the sending device |
| link_up | input | 1 | Static link status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read strobe |
| bridge_en | output | 1 | Bridge memory window enable |
| irq | output | 1 | Interrupt request line |

## Verification
An event presented before a clock edge is in the queue after that edge. It raises its pending bit and `irq` there too, because `irq` is decoded from registered pending and mask state. Read data is registered on the edge that samples `reg_rd` and reflects the state before that edge. Writes to the mask, control and head registers take effect on the edge that samples `reg_wr`. The bench drives every stimulus on a falling edge and samples the ports on the next falling edge, so each result is read exactly one rising edge after its cause. A reference model of the queue, the pending word and the control bits supplies the expected values.

// File: rtl/rp_intx_pkg.sv
package rp_intx_pkg;

   localparam int unsigned REG_W = 32;
   localparam int unsigned ADDR_W = 3;

   // Register word addresses
   typedef enum logic [ADDR_W-1:0] {
      REG_PEND  = 3'd0,
      REG_MASK  = 3'd1,
      REG_LINK  = 3'd2,
      REG_CTRL  = 3'd3,
      REG_HEADA = 3'd4,
      REG_HEADB = 3'd5
   } reg_sel_e;

   // Control/status field positions
   localparam int unsigned CTRL_BRIDGE_BIT = 0;
   localparam int unsigned CTRL_EMPTY_BIT  = 1;
   localparam int unsigned CTRL_OVF_BIT    = 2;
   localparam int unsigned CTRL_INTX_BIT   = 3;

   // Head word A field positions
   localparam int unsigned HEAD_VALID_BIT = 31;
   localparam int unsigned HEAD_LEVEL_BIT = 16;

endpackage

// File: rtl/rp_intx_ring.sv
module rp_intx_ring #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned ENT_W = 19,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [ENT_W-1:0] push_data,
   input  logic             pop,
   output logic [ENT_W-1:0] head_data,
   output logic             empty,
   output logic             push_ok,
   output logic             drop
);

   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [PTR_W-1:0] wr_nxt, rd_nxt;
   logic [DEPTH-1:0][ENT_W-1:0] mem_q;
   logic full;
   logic pop_ok;

   // Pointer advance: free wrap for powers of two, explicit wrap otherwise
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_mod_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   // One slot stays free so equal pointers always mean empty
   assign empty   = (wr_ptr == rd_ptr);
   assign full    = (wr_nxt == rd_ptr);
   assign push_ok = push && !full;
   assign drop    = push && full;
   assign pop_ok  = pop && !empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem_q[wr_ptr] <= push_data;
   end

   assign head_data = mem_q[rd_ptr];

endmodule

// File: rtl/rp_intx_pend.sv
module rp_intx_pend #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_vec,
   input  logic             clr_wr,
   input  logic [WIDTH-1:0] clr_vec,
   input  logic             mask_wr,
   input  logic [WIDTH-1:0] mask_in,
   output logic [WIDTH-1:0] pend_o,
   output logic [WIDTH-1:0] mask_o,
   output logic             irq_o
);

   logic [WIDTH-1:0] pend_q, pend_d, mask_q;

   // Per-bit write-one-to-clear with set priority
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign pend_d[i] = set_vec[i] | (pend_q[i] & ~(clr_wr & clr_vec[i]));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= '0;
      end else begin
         pend_q <= pend_d;
         if (mask_wr) mask_q <= mask_in;
      end
   end

   assign pend_o = pend_q;
   assign mask_o = mask_q;
   assign irq_o  = |(pend_q & mask_q);

endmodule

// File: rtl/rp_intx_queue.sv
module rp_intx_queue
   import rp_intx_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned LANES = 4,
   parameter int unsigned SRC_W = 16,
   localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic [LANE_W-1:0] evt_lane,
   input  logic              evt_level,
   input  logic [SRC_W-1:0]  evt_src,
   input  logic              link_up,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              bridge_en,
   output logic              irq
);

   localparam int unsigned ENT_W = 1 + LANE_W + SRC_W;

   // Elaboration-time parameter checks
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rp_intx_queue: DEPTH must be at least 2");
      end
      if (LANES < 1 || LANES > 16) begin : g_bad_lanes
         $error("rp_intx_queue: LANES must lie in 1..16");
      end
      if (SRC_W < 1 || SRC_W > REG_W) begin : g_bad_src
         $error("rp_intx_queue: SRC_W must lie in 1..32");
      end
   endgenerate

   // Register decode
   logic wr_pend, wr_mask, wr_ctrl, wr_head;
   assign wr_pend = reg_wr && (reg_addr == REG_PEND);
   assign wr_mask = reg_wr && (reg_addr == REG_MASK);
   assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
   assign wr_head = reg_wr && ((reg_addr == REG_HEADA) || (reg_addr == REG_HEADB));

   // Event queue
   logic [ENT_W-1:0] head_data;
   logic q_empty, push_ok, drop;

   rp_intx_ring #(
      .DEPTH (DEPTH),
      .ENT_W (ENT_W)
   ) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (evt_valid),
      .push_data ({evt_level, evt_lane, evt_src}),
      .pop       (wr_head),
      .head_data (head_data),
      .empty     (q_empty),
      .push_ok   (push_ok),
      .drop      (drop)
   );

   // Head words, zero while empty
   logic [REG_W-1:0] head_a, head_b;
   always_comb begin
      head_a = '0;
      head_b = '0;
      if (!q_empty) begin
         head_a[HEAD_VALID_BIT] = 1'b1;
         head_a[HEAD_LEVEL_BIT] = head_data[ENT_W-1];
         head_a[LANE_W-1:0]     = head_data[SRC_W +: LANE_W];
         head_b[SRC_W-1:0]      = head_data[SRC_W-1:0];
      end
   end

   // Pending sources: raise events per lane, drops on bit LANES
   logic [REG_W-1:0] set_vec;
   always_comb begin
      set_vec = '0;
      if (push_ok && evt_level && (int'(evt_lane) < int'(LANES))) set_vec[evt_lane] = 1'b1;
      set_vec[LANES] = drop;
   end

   logic [REG_W-1:0] pend_word, mask_word;

   rp_intx_pend #(
      .WIDTH (REG_W)
   ) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_wr  (wr_pend),
      .clr_vec (reg_wdata),
      .mask_wr (wr_mask),
      .mask_in (reg_wdata),
      .pend_o  (pend_word),
      .mask_o  (mask_word),
      .irq_o   (irq)
   );

   // Control/status state
   logic bridge_q, ovf_q, intx_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bridge_q <= 1'b0;
         ovf_q    <= 1'b0;
         intx_q   <= 1'b0;
      end else begin
         if (wr_ctrl) bridge_q <= reg_wdata[CTRL_BRIDGE_BIT];
         if (drop)    ovf_q    <= 1'b1;
         if (push_ok)
            intx_q <= 1'b1;
         else if (wr_ctrl && reg_wdata[CTRL_INTX_BIT])
            intx_q <= 1'b0;
      end
   end
   assign bridge_en = bridge_q;

   logic [REG_W-1:0] ctrl_word;
   always_comb begin
      ctrl_word = '0;
      ctrl_word[CTRL_BRIDGE_BIT] = bridge_q;
      ctrl_word[CTRL_EMPTY_BIT]  = q_empty;
      ctrl_word[CTRL_OVF_BIT]    = ovf_q;
      ctrl_word[CTRL_INTX_BIT]   = intx_q;
   end

   // Registered read port
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else if (reg_rd) begin
         case (reg_addr)
            REG_PEND:  reg_rdata <= pend_word;
            REG_MASK:  reg_rdata <= mask_word;
            REG_LINK:  reg_rdata <= REG_W'(link_up);
            REG_CTRL:  reg_rdata <= ctrl_word;
            REG_HEADA: reg_rdata <= head_a;
            REG_HEADB: reg_rdata <= head_b;
            default:   reg_rdata <= '0;
         endcase
      end
   end

endmodule

// File: rtl/rp_intx_queue_chk.sv
module rp_intx_queue_chk
   import rp_intx_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr,
   input logic        reg_rd,
   input logic [2:0]  reg_addr,
   input logic [31:0] reg_wdata,
   input logic [31:0] reg_rdata,
   input logic        link_up,
   input logic        bridge_en,
   input logic        irq,
   input logic        q_empty
);

   // R3
   empty_head_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && q_empty && ((reg_addr == REG_HEADA) || (reg_addr == REG_HEADB)))
      |=> (reg_rdata == 32'd0));

   // R7
   bridge_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (reg_addr == REG_CTRL)) |=> (bridge_en == $past(reg_wdata[CTRL_BRIDGE_BIT])));

   // R7
   bridge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && (reg_addr == REG_CTRL)) |=> $stable(bridge_en));

   // R10
   mask_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (reg_addr == REG_MASK) && (reg_wdata == 32'd0)) |=> !irq);

   // R11
   link_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && (reg_addr == REG_LINK)) |=> (reg_rdata == {31'd0, $past(link_up)}));

   // R12
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && (reg_addr > REG_HEADB)) |=> (reg_rdata == 32'd0));

endmodule

bind rp_intx_queue rp_intx_queue_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .link_up   (link_up),
   .bridge_en (bridge_en),
   .irq       (irq),
   .q_empty   (q_empty)
);

// File: tb/rp_intx_queue_bench.sv
module rp_intx_queue_bench;

   localparam int DEPTH = 5;
   localparam int LANES = 4;
   localparam int SRC_W = 16;
   localparam int CAP   = DEPTH - 1;

   localparam logic [2:0] A_PEND = 3'd0, A_MASK = 3'd1, A_LINK = 3'd2,
                          A_CTRL = 3'd3, A_HA = 3'd4, A_HB = 3'd5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic evt_valid = 1'b0;
   logic [1:0] evt_lane = '0;
   logic evt_level = 1'b0;
   logic [15:0] evt_src = '0;
   logic link_up = 1'b0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic bridge_en, irq;

   always #4 clk = ~clk;

   rp_intx_queue #(.DEPTH(DEPTH), .LANES(LANES), .SRC_W(SRC_W)) u_rp_intx_queue (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_lane(evt_lane),
      .evt_level(evt_level), .evt_src(evt_src), .link_up(link_up),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .bridge_en(bridge_en), .irq(irq)
   );

   int n_tests = 0;
   int n_fail  = 0;

   // Reference model
   logic [31:0] mq_a [16];
   logic [31:0] mq_b [16];
   int m_head = 0, m_cnt = 0;
   logic [31:0] exp_pend = '0;
   logic exp_ovf = 1'b0, exp_intx = 1'b0, exp_bridge = 1'b0;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic push_evt(int lane, bit lvl, logic [15:0] src);
      evt_valid = 1'b1; evt_lane = 2'(lane); evt_level = lvl; evt_src = src;
      @(negedge clk);
      evt_valid = 1'b0;
      if (m_cnt < CAP) begin
         mq_a[(m_head + m_cnt) % 16] = 32'h8000_0000 | (32'(lvl) << 16) | 32'(lane);
         mq_b[(m_head + m_cnt) % 16] = 32'(src);
         m_cnt++;
         exp_intx = 1'b1;
         if (lvl) exp_pend[lane] = 1'b1;
      end else begin
         exp_ovf = 1'b1;
         exp_pend[LANES] = 1'b1;
      end
   endtask

   task automatic chk_heads(string tag);
      logic [31:0] d;
      rd(A_HA, d);
      check({tag, " head A"}, d, (m_cnt > 0) ? mq_a[m_head] : 32'd0);
      rd(A_HB, d);
      check({tag, " head B"}, d, (m_cnt > 0) ? mq_b[m_head] : 32'd0);
   endtask

   task automatic chk_ctrl(string tag);
      logic [31:0] d;
      rd(A_CTRL, d);
      check({tag, " ctrl"}, d, {28'd0, exp_intx, exp_ovf, (m_cnt == 0), exp_bridge});
   endtask

   task automatic pop(bit use_b);
      wr(use_b ? A_HB : A_HA, 32'hDEAD_BEEF);
      if (m_cnt > 0) begin
         m_head = (m_head + 1) % 16;
         m_cnt--;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq", 32'(irq), 32'd0);
      check("R1 bridge_en", 32'(bridge_en), 32'd0);
      chk_ctrl("R1");
      rd(A_MASK, d); check("R1 mask", d, 32'd0);
      rd(A_PEND, d); check("R1 pending", d, 32'd0);

      // R3 empty reads, R4 pop on empty
      chk_heads("R3 empty");
      pop(1'b1);
      chk_ctrl("R4 pop on empty");
      push_evt(2, 1'b1, 16'h1234);
      chk_heads("R4 head after empty pop");
      pop(1'b0);
      chk_heads("R4 emptied");

      // R2 R5 R6 sweep over lanes, levels, fill, overflow and drain
      for (int round = 0; round < 2; round++) begin
         for (int e = 0; e < CAP + 2; e++) begin
            push_evt(e % LANES, 1'((e + round) % 2), 16'(16'hA000 + round * 256 + e * 37));
            chk_heads("R5 head stays oldest");
         end
         chk_ctrl("R6 full");
         check("R10 irq masked", 32'(irq), 32'd0);
         for (int k = 0; m_cnt > 0; k++) begin
            chk_heads("R2 read");
            chk_heads("R2 reread keeps entry");
            pop(1'(k % 2));
            chk_ctrl("R6 drain");
         end
         chk_heads("R3 drained");
      end

      // R8 clear event flag, R7 bridge enable
      wr(A_CTRL, 32'h0000_0009);
      exp_bridge = 1'b1; exp_intx = 1'b0;
      check("R7 bridge_en set", 32'(bridge_en), 32'd1);
      chk_ctrl("R8 cleared");
      push_evt(1, 1'b0, 16'h0042);
      chk_ctrl("R8 set by event");
      wr(A_CTRL, 32'hFFFF_FFF2);
      exp_bridge = 1'b0;
      check("R7 bridge_en cleared", 32'(bridge_en), 32'd0);
      chk_ctrl("R7 other bits kept");
      chk_heads("R7 queue untouched");

      // R9 R10 pending word, mask, irq
      rd(A_PEND, d); check("R9 pending", d, exp_pend);
      for (int b = 0; b <= LANES; b++) begin
         wr(A_MASK, 32'(1) << b);
         check("R10 irq single mask", 32'(irq), 32'(exp_pend[b]));
         rd(A_MASK, d); check("R10 mask readback", d, 32'(1) << b);
      end
      wr(A_MASK, 32'hFFFF_FFFF);
      check("R10 irq full mask", 32'(irq), 32'(|exp_pend));
      for (int b = 0; b <= LANES; b++) begin
         wr(A_PEND, 32'(1) << b);
         exp_pend[b] = 1'b0;
         rd(A_PEND, d); check("R9 w1c", d, exp_pend);
         check("R10 irq after clear", 32'(irq), 32'(|exp_pend));
      end
      push_evt(2, 1'b1, 16'h0777);
      check("R10 irq on raise", 32'(irq), 32'd1);
      rd(A_PEND, d); check("R9 raise sets lane", d, exp_pend);
      wr(A_MASK, 32'd0);
      check("R10 irq mask off", 32'(irq), 32'd0);

      // R11 link status
      link_up = 1'b1;
      rd(A_LINK, d); check("R11 link up", d, 32'd1);
      link_up = 1'b0;
      rd(A_LINK, d); check("R11 link down", d, 32'd0);

      // R12 unmapped reads and hold
      rd(3'd6, d); check("R12 addr 6", d, 32'd0);
      rd(A_MASK, d);
      @(negedge clk);
      check("R12 rdata holds", reg_rdata, 32'd0);
      rd(3'd7, d); check("R12 addr 7", d, 32'd0);

      finish_run();
   end

endmodule